// File: doc/BRIEF.md
# Boost Regulator Bypass Transition Controller

This block decides when a boost regulator hands its output over to a direct input-to-output path and when it takes it back. It drives the high-side pass switch (off, current-limited linear, or fully on), the rectifier pass switch (on or off), the enable of the boost modulator, and a low-power flag that lets the rest of the regulator turn off its protection circuits. All timing is counted in ticks of an external time-base strobe, so one tick stands for one time unit.

There are two paths into bypass. The automatic path starts on its own when the input is above the output target and the modulator has been quiet for a full idle window. It runs a linear soft-entry phase, then closes both switches, and returns to boost once the output sags to the target. The forced path starts on an active-low request pin. It first waits for the output to discharge below the input, then runs the same linear phase before it closes both switches. When the pin is released, the block runs one more linear phase with the rectifier open before boost resumes. A forced request wins over anything the automatic path is doing.

Top module: `bypass_ctrl`

## Requirements
- R1: After reset the block is in boost: hs_mode_o = 0, rect_on_o = 0, boost_en_o = 1, low_power_o = 0.
- R2: Automatic entry begins at the first clock edge in boost on which vin_above_tgt_i is high, sw_pulse_i is low and IDLE_TICKS ticks have been counted since the idle count last restarted. The count restarts on any sw_pulse_i, on any cycle with vin_above_tgt_i low, and on any cycle outside boost. Entry shows as hs_mode_o = 1 (linear) and boost_en_o = 0.
- R3: The automatic linear phase ends on the SOFT_TICKS-th tick after entry. From then on hs_mode_o = 2 (fully on) and rect_on_o = 1.
- R4: In the automatic linear phase or in automatic bypass, vout_at_tgt_i high with no forced request returns the block to boost on the next edge.
- R5: byp_n_i passes through a two-flop synchronizer. A low level acts as a forced request on the third rising edge after it is applied. A forced request from boost or from any automatic state moves the block to a wait state: hs_mode_o = 0, rect_on_o = 0, boost_en_o = 0.
- R6: The wait state is held while vout_below_vin_i is low. When vout_below_vin_i is high, a linear phase (hs_mode_o = 1) of SOFT_TICKS ticks starts, followed by hs_mode_o = 2 with rect_on_o = 1.
- R7: low_power_o is high only in fully entered forced bypass. Automatic bypass keeps it low.
- R8: Release of the request from any forced state enters an exit phase: hs_mode_o = 1, rect_on_o = 0, boost_en_o = 0, low_power_o = 0. This phase lasts SOFT_TICKS ticks and then goes to boost. A new request during the exit phase returns the block to the wait state.
- R9: rect_on_o is high only while hs_mode_o = 2. boost_en_o is high only while hs_mode_o = 0 and rect_on_o = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| byp_n_i | input | 1 | Forced bypass request, active low, asynchronous |
| vin_above_tgt_i | input | 1 | Input voltage is above the output target |
| sw_pulse_i | input | 1 | The modulator switched in this cycle |
| vout_at_tgt_i | input | 1 | Output has fallen to the target |
| vout_below_vin_i | input | 1 | Output is below the input |
| tick_i | input | 1 | One-cycle time-base strobe |
| hs_mode_o | output | 2 | High-side switch drive: 0 off, 1 linear, 2 fully on |
| rect_on_o | output | 1 | Rectifier pass switch on |
| boost_en_o | output | 1 | Boost modulator enable |
| low_power_o | output | 1 | Protection circuits may be turned off |

## Verification
A wrong state appears at the ports on the edge after it is reached, because every output is decoded directly from the state register. A wrong tick count moves the linear-to-full change, or the entry into automatic bypass, by whole ticks. The bench therefore compares every output in every cycle against its own model, and it probes the idle window one tick short of and at its exact length. A wrong synchronizer depth shifts the response to the request pin by one cycle, which shows up the first time the pin changes.

// File: rtl/bypass_pkg.sv
package bypass_pkg;

  typedef enum logic [2:0] {
    ST_BOOST     = 3'd0,
    ST_AUTO_SOFT = 3'd1,
    ST_AUTO_ON   = 3'd2,
    ST_FWAIT     = 3'd3,
    ST_FSOFT     = 3'd4,
    ST_FON       = 3'd5,
    ST_FEXIT     = 3'd6
  } byp_state_t;

  typedef enum logic [1:0] {
    HS_OFF  = 2'd0,
    HS_LIN  = 2'd1,
    HS_FULL = 2'd2
  } hs_drive_t;

  // states that run a timed linear phase
  function automatic logic is_soft(byp_state_t s);
    return (s == ST_AUTO_SOFT) || (s == ST_FSOFT) || (s == ST_FEXIT);
  endfunction

  // states owned by the forced-bypass path
  function automatic logic is_forced(byp_state_t s);
    return (s == ST_FWAIT) || (s == ST_FSOFT) || (s == ST_FON) || (s == ST_FEXIT);
  endfunction

  function automatic hs_drive_t hs_of(byp_state_t s);
    case (s)
      ST_AUTO_SOFT, ST_FSOFT, ST_FEXIT: return HS_LIN;
      ST_AUTO_ON, ST_FON:               return HS_FULL;
      default:                          return HS_OFF;
    endcase
  endfunction

  // width able to hold 0..n
  function automatic int cnt_width(int n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

endpackage

// File: rtl/byp_sync.sv
module byp_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_n_i,
  output logic req_o
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[g] <= 1'b1;
          else        chain_q[g] <= async_n_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[g] <= 1'b1;
          else        chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  assign req_o = ~chain_q[STAGES-1];
endmodule

// File: rtl/idle_timer.sv
module idle_timer #(
  parameter int LIMIT = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear_i,
  input  logic tick_i,
  output logic full_o
);
  localparam int W = bypass_pkg::cnt_width(LIMIT);
  localparam logic [W-1:0] LIM = W'(LIMIT);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cnt_q <= '0;
    else if (clear_i)            cnt_q <= '0;
    else if (tick_i && !full_o)  cnt_q <= cnt_q + 1'b1;
  end

  assign full_o = (cnt_q == LIM);
endmodule

// File: rtl/phase_timer.sv
module phase_timer #(
  parameter int LIMIT = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart_i,
  input  logic tick_i,
  output logic last_tick_o
);
  localparam int W = bypass_pkg::cnt_width(LIMIT);
  localparam logic [W-1:0] LAST = W'(LIMIT - 1);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       cnt_q <= '0;
    else if (restart_i)               cnt_q <= '0;
    else if (tick_i && cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
  end

  assign last_tick_o = tick_i && (cnt_q == LAST);
endmodule

// File: rtl/bypass_fsm.sv
module bypass_fsm
  import bypass_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       frc_req_i,
  input  logic       auto_ok_i,
  input  logic       at_tgt_i,
  input  logic       below_vin_i,
  input  logic       soft_done_i,
  output byp_state_t state_o,
  output byp_state_t next_o
);
  byp_state_t state_q, state_d;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_BOOST: begin
        if (frc_req_i)      state_d = ST_FWAIT;
        else if (auto_ok_i) state_d = ST_AUTO_SOFT;
      end
      ST_AUTO_SOFT: begin
        if (frc_req_i)        state_d = ST_FWAIT;
        else if (at_tgt_i)    state_d = ST_BOOST;
        else if (soft_done_i) state_d = ST_AUTO_ON;
      end
      ST_AUTO_ON: begin
        if (frc_req_i)     state_d = ST_FWAIT;
        else if (at_tgt_i) state_d = ST_BOOST;
      end
      ST_FWAIT: begin
        if (!frc_req_i)       state_d = ST_FEXIT;
        else if (below_vin_i) state_d = ST_FSOFT;
      end
      ST_FSOFT: begin
        if (!frc_req_i)       state_d = ST_FEXIT;
        else if (soft_done_i) state_d = ST_FON;
      end
      ST_FON: begin
        if (!frc_req_i) state_d = ST_FEXIT;
      end
      ST_FEXIT: begin
        if (frc_req_i)        state_d = ST_FWAIT;
        else if (soft_done_i) state_d = ST_BOOST;
      end
      default: state_d = ST_BOOST;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_BOOST;
    else        state_q <= state_d;
  end

  assign state_o = state_q;
  assign next_o  = state_d;
endmodule

// File: rtl/bypass_ctrl.sv
module bypass_ctrl
  import bypass_pkg::*;
#(
  parameter int IDLE_TICKS  = 10,
  parameter int SOFT_TICKS  = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       byp_n_i,
  input  logic       vin_above_tgt_i,
  input  logic       sw_pulse_i,
  input  logic       vout_at_tgt_i,
  input  logic       vout_below_vin_i,
  input  logic       tick_i,
  output logic [1:0] hs_mode_o,
  output logic       rect_on_o,
  output logic       boost_en_o,
  output logic       low_power_o
);
  // named internal events
  logic       frc_req;
  logic       idle_full;
  logic       idle_clear;
  logic       auto_ok;
  logic       phase_last;
  logic       soft_done;
  logic       state_change;
  byp_state_t state_q, state_d;
  hs_drive_t  hs_drive;

  byp_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .async_n_i (byp_n_i),
    .req_o     (frc_req)
  );

  assign idle_clear = (state_q != ST_BOOST) || sw_pulse_i || !vin_above_tgt_i;

  idle_timer #(.LIMIT(IDLE_TICKS)) u_idle (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear_i (idle_clear),
    .tick_i  (tick_i),
    .full_o  (idle_full)
  );

  assign auto_ok = idle_full && vin_above_tgt_i && !sw_pulse_i;

  assign state_change = (state_d != state_q);

  phase_timer #(.LIMIT(SOFT_TICKS)) u_phase (
    .clk         (clk),
    .rst_n       (rst_n),
    .restart_i   (state_change),
    .tick_i      (tick_i),
    .last_tick_o (phase_last)
  );

  assign soft_done = is_soft(state_q) && phase_last;

  bypass_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .frc_req_i   (frc_req),
    .auto_ok_i   (auto_ok),
    .at_tgt_i    (vout_at_tgt_i),
    .below_vin_i (vout_below_vin_i),
    .soft_done_i (soft_done),
    .state_o     (state_q),
    .next_o      (state_d)
  );

  assign hs_drive    = hs_of(state_q);
  assign hs_mode_o   = hs_drive;
  assign rect_on_o   = (hs_drive == HS_FULL);
  assign boost_en_o  = (state_q == ST_BOOST);
  assign low_power_o = (state_q == ST_FON) && is_forced(state_q);
endmodule

// File: rtl/bypass_ctrl_chk.sv
module bypass_ctrl_chk
  import bypass_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input byp_state_t state,
  input logic       frc_req,
  input logic       auto_ok,
  input logic       at_tgt,
  input logic       below_vin,
  input logic [1:0] hs_mode,
  input logic       rect_on,
  input logic       boost_en,
  input logic       low_power
);
  a_r9_rect_needs_full: assert property (@(posedge clk) disable iff (!rst_n)
    rect_on |-> hs_mode == HS_FULL);

  a_r9_boost_switches_idle: assert property (@(posedge clk) disable iff (!rst_n)
    boost_en |-> (hs_mode == HS_OFF) && !rect_on);

  a_r7_low_power_full_only: assert property (@(posedge clk) disable iff (!rst_n)
    low_power |-> (hs_mode == HS_FULL) && rect_on && !boost_en);

  a_r2_auto_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_BOOST && auto_ok && !frc_req) |=> (hs_mode == HS_LIN) && !boost_en);

  a_r4_auto_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_AUTO_ON && at_tgt && !frc_req) |=> boost_en);

  a_r5_forced_priority: assert property (@(posedge clk) disable iff (!rst_n)
    (frc_req && (state == ST_BOOST || state == ST_AUTO_SOFT || state == ST_AUTO_ON))
      |=> (hs_mode == HS_OFF) && !boost_en);

  a_r6_wait_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_FWAIT && frc_req && !below_vin) |=> state == ST_FWAIT);

  a_r8_release_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (!frc_req && (state == ST_FSOFT || state == ST_FON))
      |=> (hs_mode == HS_LIN) && !rect_on && !low_power);
endmodule

bind bypass_ctrl bypass_ctrl_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .state     (state_q),
  .frc_req   (frc_req),
  .auto_ok   (auto_ok),
  .at_tgt    (vout_at_tgt_i),
  .below_vin (vout_below_vin_i),
  .hs_mode   (hs_mode_o),
  .rect_on   (rect_on_o),
  .boost_en  (boost_en_o),
  .low_power (low_power_o)
);

// File: tb/tb_bypass_ctrl.sv
module tb_bypass_ctrl;
  localparam int IDLE = 10;
  localparam int SOFT = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic byp_n = 1'b1, vab = 1'b0, sw = 1'b0, at = 1'b0, below = 1'b0, tick = 1'b0;
  logic [1:0] hs;
  logic rect, ben, lp;

  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  bypass_ctrl #(.IDLE_TICKS(IDLE), .SOFT_TICKS(SOFT), .SYNC_STAGES(2)) dut (
    .clk(clk), .rst_n(rst_n), .byp_n_i(byp_n), .vin_above_tgt_i(vab),
    .sw_pulse_i(sw), .vout_at_tgt_i(at), .vout_below_vin_i(below), .tick_i(tick),
    .hs_mode_o(hs), .rect_on_o(rect), .boost_en_o(ben), .low_power_o(lp)
  );

  // reference model: 0 boost,1 auto lin,2 auto on,3 wait,4 forced lin,5 forced on,6 exit
  int m_mode, m_left, m_quiet;
  bit m_p1, m_p2;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode = 0; m_left = SOFT; m_quiet = 0; m_p1 = 1; m_p2 = 1;
    end else begin
      bit req, go;
      int nxt;
      req = !m_p2;
      go  = (m_quiet >= IDLE) && vab && !sw;
      nxt = m_mode;
      case (m_mode)
        0: nxt = req ? 3 : (go ? 1 : 0);
        1: nxt = req ? 3 : at ? 0 : (tick && m_left == 1) ? 2 : 1;
        2: nxt = req ? 3 : at ? 0 : 2;
        3: nxt = !req ? 6 : below ? 4 : 3;
        4: nxt = !req ? 6 : (tick && m_left == 1) ? 5 : 4;
        5: nxt = !req ? 6 : 5;
        default: nxt = req ? 3 : (tick && m_left == 1) ? 0 : 6;
      endcase
      if (m_mode != 0 || sw || !vab) m_quiet = 0;
      else if (tick && m_quiet < IDLE) m_quiet++;
      if (nxt != m_mode) m_left = SOFT;
      else if (tick && m_left > 1) m_left--;
      m_mode = nxt;
      m_p2 = m_p1; m_p1 = byp_n;
    end
  end

  function automatic logic [4:0] expect_out(int mode);
    logic [1:0] h;
    h = (mode == 1 || mode == 4 || mode == 6) ? 2'd1 : (mode == 2 || mode == 5) ? 2'd2 : 2'd0;
    return {h, h == 2'd2, mode == 0, mode == 5};
  endfunction

  function automatic string tag_of(int mode);
    case (mode)
      0: return "R2"; 1: return "R3"; 2: return "R4"; 3: return "R5";
      4: return "R6"; 5: return "R7"; default: return "R8";
    endcase
  endfunction

  task automatic chk(string tag, logic [4:0] act, logic [4:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s t=%0t actual=%b expected=%b", tag, $time, act, exp);
    end
  endtask

  // wait for next negedge, compare all outputs with the model
  task automatic step();
    @(negedge clk);
    chk(tag_of(m_mode), {hs, rect, ben, lp}, expect_out(m_mode));
    checks++;
    if ((rect && hs != 2'd2) || (ben && (hs != 2'd0 || rect))) begin
      errors++;
      $display("FAIL R9 actual=%b expected=consistent", {hs, rect, ben, lp});
    end
  endtask

  task automatic steps(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240607));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", {hs, rect, ben, lp}, 5'b00_0_1_0);

    // R2: idle window one tick short, then restart by a pulse
    vab = 1; tick = 1;
    steps(IDLE);
    sw = 1; step(); sw = 0;
    steps(IDLE);
    chk("R2", {hs, ben}, {2'd0, 1'b1});
    step();
    chk("R2", {hs, ben}, {2'd1, 1'b0});
    // R3: linear phase length
    steps(SOFT - 1);
    chk("R3", {hs, rect}, {2'd1, 1'b0});
    step();
    chk("R3", {hs, rect}, {2'd2, 1'b1});
    chk("R7", {28'd0, lp}, 29'd0);
    // R4: exit on output at target
    at = 1; step(); at = 0; vab = 0;
    chk("R4", {hs, ben}, {2'd0, 1'b1});

    // R5/R6/R7: forced entry
    byp_n = 0; below = 0;
    steps(2);
    chk("R5", {ben}, 1'b1);
    step();
    chk("R5", {hs, ben}, {2'd0, 1'b0});
    steps(8);
    chk("R6", {hs, rect}, {2'd0, 1'b0});
    below = 1; step();
    chk("R6", hs, 2'd1);
    steps(SOFT);
    chk("R7", {hs, rect, ben, lp}, 5'b10_1_0_1);
    // R8: release
    byp_n = 1; steps(3);
    chk("R8", {hs, rect, ben, lp}, 5'b01_0_0_0);
    steps(SOFT - 1);
    chk("R8", ben, 1'b1 ^ 1'b1);
    step();
    chk("R8", ben, 1'b1);

    // R5 priority over running auto bypass
    vab = 1; steps(IDLE + 1 + SOFT);
    chk("R3", hs, 2'd2);
    byp_n = 0; below = 0; steps(3);
    chk("R5", {hs, rect, ben}, {2'd0, 1'b0, 1'b0});
    byp_n = 1; steps(3 + SOFT);

    // random phase
    for (int i = 0; i < 6000; i++) begin
      tick = ($urandom_range(1, 0) == 1);
      sw   = ($urandom_range(11, 0) == 0);
      at   = ($urandom_range(24, 0) == 0);
      if ($urandom_range(29, 0) == 0) vab = ~vab;
      if ($urandom_range(9, 0) == 0) below = ~below;
      if ($urandom_range(59, 0) == 0) byp_n = ~byp_n;
      step();
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule